// File: doc/BRIEF.md
# Flow-Control Status Packet Generator

This block tracks how much receive data the device holds for the host and how much transmit space each of four serial ports can still accept. A single receive-available counter and one transmit credit counter per port are each moved up or down by one per strobe. When a port is opened, its credit is loaded from a one-byte buffer size code. The code means (code+1)*64 bytes.

When any counter changes, or a port is opened, the block raises an internal pending flag. It then sends one fixed status packet over a byte-wide valid/ready stream, which feeds an interrupt channel that the host polls. The packet is a copy of all five fields taken at the moment it starts. Changes that arrive while a packet is in flight cause one more packet after it. Several changes made before a packet starts are merged into that single packet.

Top module: `flowStatusPacker`

## Requirements
- R1: A packet is exactly 10 bytes: the receive-available field, then the credit fields of port 0, 1, 2 and 3. `pktLast` is high with the 10th byte and with no other byte.
- R2: Each 16-bit field is sent as two bytes, the low byte first.
- R3: No packet is produced unless a counter value has changed or a port was opened since the previous packet started.
- R4: A pulse on `portOpen[p]` loads credit p with (code+1)*64, where code is `openCode[8p+7:8p]`. A packet follows even when the loaded value equals the old one.
- R5: A single increment or decrement strobe moves its counter by one. Increment and decrement on the same counter in the same cycle leave it unchanged. An open on a port overrides that port's strobes in the same cycle.
- R6: Counters saturate at 0 and at 0xFFFF. A strobe that would cross either limit leaves the value unchanged and produces no packet.
- R7: A packet carries the values present when it starts. A change during its transfer does not alter it, and a further packet carrying the new values follows.
- R8: While `pktValid` is high and `pktReady` is low, `pktValid`, `pktData` and `pktLast` hold steady. A byte is taken on a clock edge where both are high.
- R9: After reset all counters are zero and `pktValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxInc | input | 1 | Add one to the receive-available count |
| rxDec | input | 1 | Subtract one from the receive-available count |
| creditInc | input | 4 | Per-port add one to transmit credit |
| creditDec | input | 4 | Per-port subtract one from transmit credit |
| portOpen | input | 4 | Per-port open pulse; loads the initial credit |
| openCode | input | 32 | Per-port buffer size code, 8 bits per port, port 0 in the low byte |
| pktReady | input | 1 | Consumer accepts the current byte |
| pktValid | output | 1 | A packet byte is presented |
| pktData | output | 8 | Packet byte |
| pktLast | output | 1 | Marks the final byte of a packet |

## Verification
The bench builds the block with its default parameters: four ports, 16-bit counters, 8-bit size codes and a 64-byte credit unit. With 16-bit counters, a single held increment strobe can push the receive count to its upper limit in about 65 thousand cycles, so both saturation edges are checked at full scale. The 8-bit code reaches the largest open credit, 16384. The stalled-consumer case, with the ready line held low, shows a packet frozen on its snapshot while a later change queues the packet that follows it.

// File: rtl/flowPktPkg.sv
package flowPktPkg;

  // strobes the control issues to the datapath
  typedef struct packed {
    logic snapLoad;  // capture all fields into the shift register
    logic advance;   // shift out the byte just accepted
  } pktCtrlT;

endpackage

// File: rtl/flowCounter.sv
module flowCounter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         incStb,
  input  logic         decStb,
  input  logic         loadStb,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] count,
  output logic         touched
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] nextCount;

  always_comb begin
    nextCount = count;
    if (loadStb) begin
      nextCount = loadVal;
    end else if (incStb && !decStb && count != TOP) begin
      nextCount = count + W'(1);
    end else if (decStb && !incStb && count != '0) begin
      nextCount = count - W'(1);
    end
  end

  // an open always counts as a reportable event
  assign touched = loadStb || (nextCount != count);

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else       count <= nextCount;
  end

endmodule

// File: rtl/statusDatapath.sv
module statusDatapath
  import flowPktPkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int CNT_W      = 16,
  parameter int CODE_W     = 8,
  parameter int UNIT_SHIFT = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          rxInc,
  input  logic                          rxDec,
  input  logic [NUM_PORTS-1:0]          creditInc,
  input  logic [NUM_PORTS-1:0]          creditDec,
  input  logic [NUM_PORTS-1:0]          portOpen,
  input  logic [NUM_PORTS*CODE_W-1:0]   openCode,
  input  pktCtrlT                       ctrl,
  output logic                          anyChange,
  output logic [7:0]                    byteOut,
  output logic [(NUM_PORTS+1)*CNT_W-1:0] fieldFlat
);

  localparam int NUM_FIELDS = NUM_PORTS + 1;
  localparam int PKT_W      = NUM_FIELDS * CNT_W;

  logic [NUM_FIELDS-1:0] touched;
  logic [PKT_W-1:0]      snapReg;

  // field 0: receive-available count, never loaded
  flowCounter #(.W(CNT_W)) rxCounter (
    .clk     (clk),
    .rstN    (rstN),
    .incStb  (rxInc),
    .decStb  (rxDec),
    .loadStb (1'b0),
    .loadVal ('0),
    .count   (fieldFlat[CNT_W-1:0]),
    .touched (touched[0])
  );

  // fields 1..NUM_PORTS: per-port transmit credit
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_credit
    logic [CNT_W-1:0] openCredit;
    assign openCredit = (CNT_W'(openCode[p*CODE_W +: CODE_W]) + CNT_W'(1)) << UNIT_SHIFT;

    flowCounter #(.W(CNT_W)) creditCounter (
      .clk     (clk),
      .rstN    (rstN),
      .incStb  (creditInc[p]),
      .decStb  (creditDec[p]),
      .loadStb (portOpen[p]),
      .loadVal (openCredit),
      .count   (fieldFlat[(p+1)*CNT_W +: CNT_W]),
      .touched (touched[p+1])
    );
  end

  assign anyChange = |touched;

  // snapshot shifter: low byte of field 0 leaves first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapReg <= '0;
    end else if (ctrl.snapLoad) begin
      snapReg <= fieldFlat;
    end else if (ctrl.advance) begin
      snapReg <= snapReg >> 8;
    end
  end

  assign byteOut = snapReg[7:0];

endmodule

// File: rtl/statusControl.sv
module statusControl
  import flowPktPkg::*;
#(
  parameter int PKT_BYTES = 10
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    anyChange,
  input  logic    pktReady,
  output logic    pktValid,
  output logic    pktLast,
  output pktCtrlT ctrl
);

  localparam int IDX_W = $clog2(PKT_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BYTES - 1);

  logic             pending;
  logic             busy;
  logic [IDX_W-1:0] byteIdx;
  logic             startPkt;
  logic             byteTaken;
  logic             finalTaken;

  assign startPkt   = !busy && pending;
  assign byteTaken  = busy && pktReady;
  assign finalTaken = byteTaken && (byteIdx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      busy    <= 1'b0;
      byteIdx <= '0;
    end else begin
      // a change in the launch cycle keeps the flag up for the next packet
      pending <= anyChange || (pending && !startPkt);
      if (startPkt) begin
        busy    <= 1'b1;
        byteIdx <= '0;
      end else if (finalTaken) begin
        busy    <= 1'b0;
      end else if (byteTaken) begin
        byteIdx <= byteIdx + IDX_W'(1);
      end
    end
  end

  assign pktValid      = busy;
  assign pktLast       = busy && (byteIdx == LAST_IDX);
  assign ctrl.snapLoad = startPkt;
  assign ctrl.advance  = byteTaken && !finalTaken;

endmodule

// File: rtl/flowStatusPacker.sv
module flowStatusPacker
  import flowPktPkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int CNT_W      = 16,
  parameter int CODE_W     = 8,
  parameter int UNIT_SHIFT = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        rxInc,
  input  logic                        rxDec,
  input  logic [NUM_PORTS-1:0]        creditInc,
  input  logic [NUM_PORTS-1:0]        creditDec,
  input  logic [NUM_PORTS-1:0]        portOpen,
  input  logic [NUM_PORTS*CODE_W-1:0] openCode,
  input  logic                        pktReady,
  output logic                        pktValid,
  output logic [7:0]                  pktData,
  output logic                        pktLast
);

  localparam int NUM_FIELDS = NUM_PORTS + 1;
  localparam int PKT_BYTES  = NUM_FIELDS * (CNT_W / 8);

  pktCtrlT                       ctrl;
  logic                          anyChange;
  logic [NUM_FIELDS*CNT_W-1:0]   fieldFlat;

  statusDatapath #(
    .NUM_PORTS  (NUM_PORTS),
    .CNT_W      (CNT_W),
    .CODE_W     (CODE_W),
    .UNIT_SHIFT (UNIT_SHIFT)
  ) datapath (
    .clk       (clk),
    .rstN      (rstN),
    .rxInc     (rxInc),
    .rxDec     (rxDec),
    .creditInc (creditInc),
    .creditDec (creditDec),
    .portOpen  (portOpen),
    .openCode  (openCode),
    .ctrl      (ctrl),
    .anyChange (anyChange),
    .byteOut   (pktData),
    .fieldFlat (fieldFlat)
  );

  statusControl #(
    .PKT_BYTES (PKT_BYTES)
  ) control (
    .clk       (clk),
    .rstN      (rstN),
    .anyChange (anyChange),
    .pktReady  (pktReady),
    .pktValid  (pktValid),
    .pktLast   (pktLast),
    .ctrl      (ctrl)
  );

endmodule

// File: rtl/flowStatusPackerChecker.sv
module flowStatusPackerChecker #(
  parameter int NUM_PORTS  = 4,
  parameter int CNT_W      = 16,
  parameter int CODE_W     = 8,
  parameter int UNIT_SHIFT = 6
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          rxInc,
  input logic                          rxDec,
  input logic [NUM_PORTS-1:0]          portOpen,
  input logic [NUM_PORTS*CODE_W-1:0]   openCode,
  input logic                          pktReady,
  input logic                          pktValid,
  input logic [7:0]                    pktData,
  input logic                          pktLast,
  input logic [(NUM_PORTS+1)*CNT_W-1:0] fieldFlat
);

  localparam logic [CNT_W-1:0] TOP = '1;

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    pktLast |-> pktValid); // R1

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktReady) |=> (pktValid && $stable(pktData) && $stable(pktLast))); // R8

  AST_RX_TOP_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (fieldFlat[CNT_W-1:0] == TOP && rxInc && !rxDec) |=> (fieldFlat[CNT_W-1:0] == TOP)); // R6

  AST_RX_BOTTOM_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (fieldFlat[CNT_W-1:0] == '0 && rxDec && !rxInc) |=> (fieldFlat[CNT_W-1:0] == '0)); // R6

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_open
    AST_OPEN_LOADS: assert property (@(posedge clk) disable iff (!rstN)
      portOpen[p] |=> (fieldFlat[(p+1)*CNT_W +: CNT_W] ==
        ((CNT_W'($past(openCode[p*CODE_W +: CODE_W])) + CNT_W'(1)) << UNIT_SHIFT))); // R4
  end

endmodule

bind flowStatusPacker flowStatusPackerChecker #(
  .NUM_PORTS  (NUM_PORTS),
  .CNT_W      (CNT_W),
  .CODE_W     (CODE_W),
  .UNIT_SHIFT (UNIT_SHIFT)
) checker0 (
  .clk       (clk),
  .rstN      (rstN),
  .rxInc     (rxInc),
  .rxDec     (rxDec),
  .portOpen  (portOpen),
  .openCode  (openCode),
  .pktReady  (pktReady),
  .pktValid  (pktValid),
  .pktData   (pktData),
  .pktLast   (pktLast),
  .fieldFlat (fieldFlat)
);

// File: tb/flowStatusPacker_test.sv
`timescale 1ns/1ps
module flowStatusPacker_test;

  localparam int NP = 4;
  localparam int KW = 8;
  localparam int PB = (NP + 1) * 2;

  typedef struct packed {
    logic [1:0]  port;
    logic [7:0]  code;
    logic [7:0]  steps;
    logic [15:0] rxExp;
    logic [15:0] crExp;
  } vecT;

  // open a port, add receive bytes, expect these two fields in the final packet
  localparam vecT VEC [4] = '{
    '{2'd0, 8'h00, 8'd3, 16'd3,  16'd64},
    '{2'd1, 8'h0F, 8'd5, 16'd8,  16'd1024},
    '{2'd2, 8'hFF, 8'd0, 16'd8,  16'd16384},
    '{2'd3, 8'h3F, 8'd2, 16'd10, 16'd4096}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxInc = 1'b0, rxDec = 1'b0;
  logic [NP-1:0] creditInc = '0, creditDec = '0, portOpen = '0;
  logic [NP*KW-1:0] openCode = '0;
  logic pktReady = 1'b0;
  logic pktValid, pktLast;
  logic [7:0] pktData;

  always #2.5 clk = ~clk;

  flowStatusPacker uut (
    .clk(clk), .rstN(rstN), .rxInc(rxInc), .rxDec(rxDec),
    .creditInc(creditInc), .creditDec(creditDec), .portOpen(portOpen),
    .openCode(openCode), .pktReady(pktReady), .pktValid(pktValid),
    .pktData(pktData), .pktLast(pktLast)
  );

  int nChecks = 0, nFails = 0;
  int expRx = 0;
  int expCr [NP];
  logic [7:0] pkt [PB];
  int firstRx;
  bit done = 0;

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // hold one rx strobe for n cycles: n steps
  task automatic rxBurst(bit up, int n);
    if (n > 0) begin
      @(negedge clk); rxInc = up; rxDec = !up;
      repeat (n) @(negedge clk);
      rxInc = 0; rxDec = 0;
      if (up) expRx = (expRx + n > 65535) ? 65535 : expRx + n;
      else    expRx = (expRx - n < 0) ? 0 : expRx - n;
    end
  endtask

  task automatic openPort(int p, int code);
    @(negedge clk); portOpen[p] = 1; openCode[p*KW +: KW] = 8'(code);
    @(negedge clk); portOpen = '0;
    expCr[p] = (code + 1) * 64;
  endtask

  // accept every byte until the stream has been quiet for 20 cycles
  task automatic drain(output int count);
    int idx = 0;
    int quiet = 0;
    count = 0;
    @(negedge clk); pktReady = 1;
    while (quiet < 20) begin
      if (pktValid) begin
        quiet = 0;
        pkt[idx] = pktData;
        if (pktLast) begin
          check("R1 last-flag position", idx, PB - 1);
          if (count == 0) firstRx = {pkt[1], pkt[0]};
          idx = 0; count++;
        end else if (idx == PB - 1) begin
          check("R1 missing last flag", 0, 1);
          idx = 0;
        end else begin
          idx++;
        end
      end else begin
        quiet++;
      end
      @(negedge clk);
    end
    pktReady = 0;
  endtask

  task automatic comparePkt(string tag);
    check({tag, " R2 rx field"}, {pkt[1], pkt[0]}, expRx);
    for (int p = 0; p < NP; p++)
      check({tag, " R1 credit field"}, {pkt[2*p+3], pkt[2*p+2]}, expCr[p]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    int n;
    for (int p = 0; p < NP; p++) expCr[p] = 0;
    repeat (3) @(negedge clk);
    check("R9 valid in reset", pktValid, 0);
    rstN = 1;

    // R9 / R3: quiet after reset
    drain(n);
    check("R3 no packet without change", n, 0);

    // table walk
    for (int i = 0; i < 4; i++) begin
      openPort(VEC[i].port, VEC[i].code);
      rxBurst(1, VEC[i].steps);
      drain(n);
      check("R3 packet after change", int'(n >= 1), 1);
      comparePkt("table");
      check("R1 rx vector", {pkt[1], pkt[0]}, VEC[i].rxExp);
      check("R4 credit vector", {pkt[2*VEC[i].port+3], pkt[2*VEC[i].port+2]}, VEC[i].crExp);
    end

    // R5: inc and dec together leave counters alone
    @(negedge clk); rxInc = 1; rxDec = 1; creditInc[2] = 1; creditDec[2] = 1;
    @(negedge clk); rxInc = 0; rxDec = 0; creditInc = '0; creditDec = '0;
    drain(n);
    check("R5 simultaneous inc/dec no packet", n, 0);

    // R5: single decrements on port 0
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); creditDec[0] = 1;
      @(negedge clk); creditDec[0] = 0;
    end
    expCr[0] = expCr[0] - 3;
    drain(n);
    comparePkt("R5 decrement");

    // R5: open wins over a same-cycle increment
    @(negedge clk); portOpen[1] = 1; openCode[KW +: KW] = 8'h01; creditInc[1] = 1;
    @(negedge clk); portOpen = '0; creditInc = '0;
    expCr[1] = 128;
    drain(n);
    check("R5 open priority", {pkt[5], pkt[4]}, 128);

    // R4: reopening with an equal value still reports
    openPort(1, 1);
    drain(n);
    check("R4 reopen reports", int'(n >= 1), 1);
    comparePkt("R4 reopen");

    // R6: bottom saturation
    rxBurst(0, expRx);
    drain(n);
    comparePkt("R6 to zero");
    rxBurst(0, 1);
    drain(n);
    check("R6 no packet below zero", n, 0);

    // R6: top saturation
    rxBurst(1, 65535);
    drain(n);
    comparePkt("R6 to top");
    rxBurst(1, 3);
    drain(n);
    check("R6 no packet above top", n, 0);

    // R7 / R8: stalled packet keeps its snapshot
    rxBurst(0, 1);
    while (!pktValid) @(negedge clk);
    check("R2 low byte first", pktData, 8'hFE);
    repeat (4) begin
      @(negedge clk);
      check("R8 stall holds data", {pktValid, pktData}, {1'b1, 8'hFE});
    end
    rxBurst(0, 1);
    drain(n);
    check("R7 second packet follows", n, 2);
    check("R7 first packet snapshot", firstRx, 65534);
    comparePkt("R7 second packet");

    done = 1;
    finishRun();
  end

endmodule